// File: doc/BRIEF.md
# Analysis Overhead Budget Controller

This block limits how much of a monitored domain's run time goes to slow instrumented analysis. A free-running tick marks units of time. Each tick is charged either to analysis or to native execution, depending on a status flag from the analysis engine. Ticks are grouped into accounting windows of programmable length. When the analysis ticks charged in the current window reach a programmable budget, the controller enters a sampling state and raises `sampling_active`. This tells the analysis engine to stop following flows for the rest of the window.

While sampling is active and the domain is still inside analysis, the controller issues drop requests on `drop_meta`. The engine responds by abandoning the dataflow it is on and clearing the metadata of every value that flow touches. A skipped flow therefore leaves no stale taint behind that could later cause a false report. Each drop decision is stochastic. A 16-bit LFSR is compared against a programmable drop probability, and a probability of all ones gives the strict policy: drop on every cycle once the budget is spent.

The controller has two states. ST_ACCRUE is the state in which analysis time is being charged. ST_SAMPLE is the state in which the budget is spent. The transition "budget reached" goes from ST_ACCRUE to ST_SAMPLE. The transition "window end" returns to ST_ACCRUE from either state and takes priority over "budget reached".

Top module: `ovb_budget_ctrl`

## Requirements
- R1: While reset is applied and right after it, `sampling_active` and `drop_meta` are 0.
- R2: Only cycles with `tick`=1 and `in_analysis`=1 consume budget. Ticks with `in_analysis`=0 count toward the window length but never toward the budget.
- R3: `sampling_active` becomes 1 at the clock edge where the count of analysis ticks in the current window reaches `budget_ticks`.
- R4: With `budget_ticks`=0, `sampling_active` becomes 1 at the first clock edge after reset or after a window end.
- R5: The edge that carries the `window_ticks`-th tick of a window ends that window. At that edge both tick counts clear and `sampling_active` returns to 0. An analysis tick on that same edge is not charged. A `window_ticks` value of 0 acts as 1.
- R6: `drop_meta` is combinational and equals `sampling_active` AND `in_analysis` AND (LFSR value <= `drop_prob`, unsigned).
- R7: With `drop_prob`=16'hFFFF, `drop_meta` is 1 on every cycle in which sampling and analysis are both active. With `drop_prob`=0, `drop_meta` is never 1.
- R8: The LFSR is loaded with 16'hACE1 by reset. On every clock edge out of reset it shifts left, and bit 0 takes the XOR of bits 15, 13, 12 and 10.
- R9: `drop_meta` stays 0 whenever `sampling_active` is 0, whatever the values of `in_analysis` and `drop_prob`.
- R10: Once `sampling_active` is 1, it stays 1 until a window end, even if `in_analysis` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | One unit of elapsed time |
| in_analysis | input | 1 | Domain currently runs under analysis |
| budget_ticks | input | CNT_W | Analysis ticks allowed per window |
| window_ticks | input | CNT_W | Window length in ticks |
| drop_prob | input | 16 | Drop threshold compared with the LFSR |
| sampling_active | output | 1 | Budget spent, analysis must stop |
| drop_meta | output | 1 | Request to drop the current flow and clear its metadata |

## Verification
A vector table tries several tick mixes: analysis ticks only, native ticks first and analysis ticks after, totals just under the window length and totals that land exactly on it, and budgets of zero, one and many. Together these cases separate correct budget charging from charging native ticks, from off-by-one reach detection, and from a missing window clear. Directed runs pin the exact edges at which the budget is reached and at which the window ends. They also sweep the drop probability at zero, at all ones and at half scale against an LFSR model, which separates the probability compare, the tap set and the seed.

// File: rtl/ovb_pkg.sv
package ovb_pkg;
    typedef enum logic [0:0] {
        ST_ACCRUE = 1'b0,
        ST_SAMPLE = 1'b1
    } ovb_state_e;

    localparam int          RNG_W    = 16;
    localparam logic [15:0] RNG_SEED = 16'hACE1;

    // one step of the maximal-length shift register, taps 16,14,13,11
    function automatic logic [15:0] rng_step(input logic [15:0] s);
        return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction
endpackage

// File: rtl/ovb_window_ctr.sv
module ovb_window_ctr #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [CNT_W-1:0] window_ticks,
    output logic             win_end
);
    logic [CNT_W-1:0] win_cnt;
    logic [CNT_W:0]   win_inc;

    always_comb begin
        win_inc = {1'b0, win_cnt} + {{CNT_W{1'b0}}, 1'b1};
        win_end = tick && (win_inc >= {1'b0, window_ticks});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       win_cnt <= '0;
        else if (win_end) win_cnt <= '0;
        else if (tick)    win_cnt <= win_inc[CNT_W-1:0];
    end
endmodule

// File: rtl/ovb_ana_ctr.sv
module ovb_ana_ctr #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             in_analysis,
    input  logic             clr,
    input  logic [CNT_W-1:0] budget_ticks,
    output logic             reached
);
    logic [CNT_W-1:0] ana_cnt;
    logic [CNT_W-1:0] ana_nxt;
    logic             charge;

    always_comb begin
        charge  = tick && in_analysis;
        ana_nxt = (charge && (ana_cnt != {CNT_W{1'b1}})) ? ana_cnt + 1'b1 : ana_cnt;
        reached = ana_nxt >= budget_ticks;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   ana_cnt <= '0;
        else if (clr) ana_cnt <= '0;
        else          ana_cnt <= ana_nxt;
    end
endmodule

// File: rtl/ovb_rng.sv
module ovb_rng
    import ovb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    output logic [RNG_W-1:0] rng
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rng <= RNG_SEED;
        else        rng <= rng_step(rng);
    end
endmodule

// File: rtl/ovb_budget_ctrl.sv
module ovb_budget_ctrl
    import ovb_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             in_analysis,
    input  logic [CNT_W-1:0] budget_ticks,
    input  logic [CNT_W-1:0] window_ticks,
    input  logic [15:0]      drop_prob,
    output logic             sampling_active,
    output logic             drop_meta
);
    ovb_state_e       state, state_nxt;
    logic             win_end;
    logic             reached;
    logic [RNG_W-1:0] rng;

    ovb_window_ctr #(.CNT_W(CNT_W)) u_win (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .window_ticks(window_ticks), .win_end(win_end)
    );

    ovb_ana_ctr #(.CNT_W(CNT_W)) u_ana (
        .clk(clk), .rst_n(rst_n), .tick(tick), .in_analysis(in_analysis),
        .clr(win_end), .budget_ticks(budget_ticks), .reached(reached)
    );

    ovb_rng u_rng (.clk(clk), .rst_n(rst_n), .rng(rng));

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_ACCRUE: if (win_end)      state_nxt = ST_ACCRUE;
                       else if (reached) state_nxt = ST_SAMPLE;
            ST_SAMPLE: if (win_end)      state_nxt = ST_ACCRUE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_ACCRUE;
        else        state <= state_nxt;
    end

    always_comb begin
        sampling_active = (state == ST_SAMPLE);
        drop_meta       = sampling_active && in_analysis && (rng <= drop_prob);
    end
endmodule

// File: rtl/ovb_budget_chk.sv
module ovb_budget_chk #(
    parameter int CNT_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             in_analysis,
    input logic [CNT_W-1:0] budget_ticks,
    input logic [CNT_W-1:0] window_ticks,
    input logic [15:0]      drop_prob,
    input logic             sampling_active,
    input logic             drop_meta
);
    p_drop_needs_sampling_r9: assert property (@(posedge clk) disable iff (!rst_n)
        drop_meta |-> sampling_active);

    p_drop_needs_analysis_r6: assert property (@(posedge clk) disable iff (!rst_n)
        drop_meta |-> in_analysis);

    p_always_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sampling_active && in_analysis && drop_prob == 16'hFFFF) |-> drop_meta);

    p_never_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_prob == 16'h0000) |-> !drop_meta);

    p_fall_on_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sampling_active) |-> $past(tick));

    p_native_no_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!sampling_active && !(tick && in_analysis) && budget_ticks != '0
         && $stable(budget_ticks)) |=> !sampling_active);

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (sampling_active && !tick) |=> sampling_active);
endmodule

bind ovb_budget_ctrl ovb_budget_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/tb_ovb_budget_ctrl.sv
module tb_ovb_budget_ctrl;
    localparam int CW = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick = 1'b0;
    logic          in_analysis = 1'b0;
    logic [CW-1:0] budget_ticks = '0;
    logic [CW-1:0] window_ticks = '0;
    logic [15:0]   drop_prob = '0;
    logic          sampling_active, drop_meta;

    int total = 0;
    int bad   = 0;
    logic [15:0] mrng;

    always #2 clk = ~clk;

    ovb_budget_ctrl #(.CNT_W(CW)) dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .in_analysis(in_analysis),
        .budget_ticks(budget_ticks), .window_ticks(window_ticks),
        .drop_prob(drop_prob), .sampling_active(sampling_active),
        .drop_meta(drop_meta)
    );

    // R8 reference shift register
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) mrng <= 16'hACE1;
        else        mrng <= {mrng[14:0], ^{mrng[15], mrng[13], mrng[12], mrng[10]}};
    end

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; tick = 1'b0; in_analysis = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic cyc(input logic t, input logic a);
        tick = t; in_analysis = a;
        @(negedge clk);
    endtask

    // budget, window, analysis ticks, native ticks (applied first), expected sampling
    localparam int VEC [10][5] = '{
        '{4, 100,  3,  0, 0},
        '{4, 100,  4,  0, 1},
        '{4, 100,  3, 50, 0},
        '{0, 100,  0,  0, 1},
        '{5,   8,  5,  0, 1},
        '{5,   8,  5,  3, 0},
        '{2,   8,  3,  5, 0},
        '{2,  10,  2,  6, 1},
        '{1,   0,  1,  0, 0},
        '{3, 100, 10,  0, 1}
    };

    initial begin
        #400000;
        bad++; total++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1 during and after reset
        drop_prob = 16'hFFFF; in_analysis = 1'b1; budget_ticks = 24'd5; window_ticks = 24'd100;
        @(negedge clk);
        check("R1 sampling in reset", sampling_active, 0);
        check("R1 drop in reset", drop_meta, 0);
        do_reset();
        check("R1 sampling after reset", sampling_active, 0);
        drop_prob = 16'h0000;

        // R2 R3 R4 R5 table
        for (int i = 0; i < 10; i++) begin
            budget_ticks = VEC[i][0][CW-1:0];
            window_ticks = VEC[i][1][CW-1:0];
            do_reset();
            for (int k = 0; k < VEC[i][3]; k++) cyc(1'b1, 1'b0);
            for (int k = 0; k < VEC[i][2]; k++) cyc(1'b1, 1'b1);
            cyc(1'b0, 1'b0);
            check($sformatf("R2/R3/R5 vector %0d", i), sampling_active, VEC[i][4]);
        end

        // R3 exact edge
        budget_ticks = 24'd3; window_ticks = 24'd1000; do_reset();
        cyc(1'b1, 1'b1); cyc(1'b1, 1'b1);
        check("R3 before reach", sampling_active, 0);
        cyc(1'b1, 1'b1);
        check("R3 at reach", sampling_active, 1);

        // R10 hold with analysis low
        repeat (5) cyc(1'b0, 1'b0);
        check("R10 held", sampling_active, 1);

        // R4 R5 exact window edge
        budget_ticks = 24'd0; window_ticks = 24'd4; do_reset();
        cyc(1'b0, 1'b0);
        check("R4 zero budget", sampling_active, 1);
        cyc(1'b1, 1'b0); cyc(1'b1, 1'b0); cyc(1'b1, 1'b0);
        check("R5 before window end", sampling_active, 1);
        cyc(1'b1, 1'b0);
        check("R5 at window end", sampling_active, 0);
        cyc(1'b0, 1'b0);
        check("R4 after window end", sampling_active, 1);

        // R9 no drop outside sampling
        budget_ticks = 24'd50; window_ticks = 24'd1000; drop_prob = 16'hFFFF; do_reset();
        tick = 1'b0; in_analysis = 1'b1; #1;
        check("R9 no drop", drop_meta, 0);
        @(negedge clk);

        // R7 always / never
        budget_ticks = 24'd0; do_reset();
        cyc(1'b0, 1'b1);
        begin
            int ones = 0;
            for (int k = 0; k < 8; k++) begin #1; ones += drop_meta; @(negedge clk); end
            check("R7 always drop", ones, 8);
        end
        in_analysis = 1'b0; #1;
        check("R6 no drop without analysis", drop_meta, 0);
        drop_prob = 16'h0000; in_analysis = 1'b1;
        begin
            int ones = 0;
            for (int k = 0; k < 8; k++) begin #1; ones += drop_meta; @(negedge clk); end
            check("R7 never drop", ones, 0);
        end

        // R6 R8 half-scale probability against model
        drop_prob = 16'h8000; do_reset();
        cyc(1'b0, 1'b1);
        begin
            int mism = 0;
            int hits = 0;
            for (int k = 0; k < 64; k++) begin
                #1;
                if (drop_meta != (mrng <= drop_prob)) mism++;
                hits += drop_meta;
                @(negedge clk);
            end
            check("R8 sequence mismatches", mism, 0);
            check("R6 some drops", (hits > 8 && hits < 56) ? 1 : 0, 1);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule